// File: doc/BRIEF.md
# Stereo Volume and Soft Mute Stage

This block scales a stereo stream of signed playback samples, one pair per sample strobe. A 6-bit attenuation code chooses one gain, and that gain is applied to both channels. The code map is not linear. It moves in 1 dB steps over most of its range, takes coarser steps near the bottom, and ends in a band of codes that gives silence.

On top of the volume gain sits a ramp gain that follows a raised-cosine curve. This avoids clicks when the output is silenced or restored. Two events drive the ramp. A user mute walks the curve slowly, over 1024 samples. Switching the playback path off or on walks it quickly, over 128 samples. When mute is released, the ramp climbs back from wherever it stands at that moment, so the output never jumps.

Each output sample is the input multiplied by both gains, rounded and held to the sample width. The result is registered and presented one clock after the strobe, together with a valid flag.

Top module: `stereo_atten_ramp`

## Requirements
- R1: Codes 0 and 1 give 0 dB. A code n from 2 to 51 gives n-1 dB. The volume gain for d dB is round(32768 * 10^(-d/20)), so 32768 stands for unity.
- R2: Code 52 gives 52 dB, 53 gives 54 dB, 54 gives 57 dB, 55 gives 60 dB and 56 gives 66 dB, using the same gain formula as R1.
- R3: Codes 57 to 63 give a volume gain of 0, so both outputs are 0.
- R4: The left and right channels always use the same volume gain and the same ramp gain.
- R5: On a clock edge with `smp_valid` high, each output is set to floor((x * Gv * Gr + 2^29) / 2^30), saturated to the signed 24-bit range. Here x is the input, Gv the volume gain and Gr the ramp gain in use before that edge. `out_valid` is the registered copy of `smp_valid`. Outputs keep their value on edges without a strobe.
- R6: The ramp position p runs from 0 to 128. The ramp gain is Gr(p) = round(32768 * (1 - cos(pi*p/128)) / 2).
- R7: A sample counter advances by one on every strobe, wrapping modulo 8. While `play_en` and `mute` are both high, p drops by one on each strobe where the counter equals 7, and stops at 0.
- R8: After mute is released, while `play_en` is high and p has not been raised by a power-up ramp since the last mute, p rises by one on each strobe where the counter equals 7. It starts from its current value and stops at 128.
- R9: While `play_en` is low, p drops by one on every strobe, stopping at 0, and a fast-ramp flag is set.
- R10: While the fast flag is set and `play_en` is high with mute low, p rises by one on every strobe. A strobe with `play_en` and `mute` both high clears the flag.
- R11: Reset clears p, the sample counter, both outputs and `out_valid`, and sets the fast flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | Sample strobe, one clock wide |
| smp_left | input | 24 | Left input sample, two's complement |
| smp_right | input | 24 | Right input sample, two's complement |
| atten_code | input | 6 | Attenuation code |
| mute | input | 1 | Soft mute request |
| play_en | input | 1 | Playback path powered |
| out_valid | output | 1 | Output sample valid |
| out_left | output | 24 | Scaled left sample |
| out_right | output | 24 | Scaled right sample |

## Verification
The hardest states to reach are a ramp reversal partway along the curve. One case is a mute release halfway down a slow roll-off. Another is a mute applied during a fast power-up ramp, which must switch the climb to the slow rate in the other direction. The stimulus gets there by holding a control level for a chosen number of strobes (for example 600 samples of mute) and then flipping it. A behavioural model tracks the ramp position and the counter phase, so every output cycle on both sides of the reversal is compared.

// File: rtl/sar_pkg.sv
package sar_pkg;

   localparam real PI_C      = 3.14159265358979323846;
   localparam real ONE_DB_C  = 0.89125093813374556;   // 10^(-1/20)

   // attenuation in dB for a code, -1 meaning silence
   function automatic int code_to_db(input int code);
      int db;
      if (code <= 1)       db = 0;
      else if (code <= 51) db = code - 1;
      else begin
         case (code)
            52:      db = 52;
            53:      db = 54;
            54:      db = 57;
            55:      db = 60;
            56:      db = 66;
            default: db = -1;
         endcase
      end
      return db;
   endfunction

   function automatic int vol_gain(input int code, input int unity);
      int  db;
      real r;
      db = code_to_db(code);
      if (db < 0) return 0;
      r = 1.0;
      for (int i = 0; i < db; i++) r = r * ONE_DB_C;
      return $rtoi(r * real'(unity) + 0.5);
   endfunction

   // raised-cosine ramp value, cosine by series expansion
   function automatic int ramp_gain(input int p, input int len, input int unity);
      real x, term, c;
      x    = PI_C * real'(p) / real'(len);
      term = 1.0;
      c    = 1.0;
      for (int i = 1; i <= 24; i++) begin
         term = -term * x * x / real'((2*i-1) * (2*i));
         c    = c + term;
      end
      return $rtoi(real'(unity) * (1.0 - c) / 2.0 + 0.5);
   endfunction

endpackage

// File: rtl/sar_vol_rom.sv
module sar_vol_rom #(
   parameter int CODE_W = 6,
   parameter int GAIN_W = 16
) (
   input  logic [CODE_W-1:0] code,
   output logic [GAIN_W-1:0] gain
);
   localparam int ENTRIES = 2 ** CODE_W;
   localparam int UNITY   = 2 ** (GAIN_W - 1);

   logic [GAIN_W-1:0] tab [ENTRIES];

   for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
      localparam int GV = sar_pkg::vol_gain(g, UNITY);
      assign tab[g] = GAIN_W'(GV);
   end

   assign gain = tab[code];
endmodule

// File: rtl/sar_ramp.sv
module sar_ramp #(
   parameter int RAMP_LEN = 128,
   parameter int MUTE_DIV = 8,
   parameter int GAIN_W   = 16,
   localparam int PW      = $clog2(RAMP_LEN + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              step_en,
   input  logic              play_en,
   input  logic              mute,
   output logic [PW-1:0]     pos,
   output logic [GAIN_W-1:0] gain
);
   localparam int DVW   = $clog2(MUTE_DIV);
   localparam int UNITY = 2 ** (GAIN_W - 1);

   logic [GAIN_W-1:0] tab [RAMP_LEN+1];
   for (genvar k = 0; k <= RAMP_LEN; k++) begin : g_pt
      localparam int RV = sar_pkg::ramp_gain(k, RAMP_LEN, UNITY);
      assign tab[k] = GAIN_W'(RV);
   end

   logic [DVW-1:0] div_q;
   logic           fast_q, fast_n;
   logic [PW-1:0]  pos_n;
   logic           slow_tick;

   assign slow_tick = (div_q == DVW'(MUTE_DIV - 1));

   always_comb begin
      pos_n  = pos;
      fast_n = fast_q;
      if (!play_en) begin
         fast_n = 1'b1;
         if (pos != '0) pos_n = pos - PW'(1);
      end else if (mute) begin
         fast_n = 1'b0;
         if (slow_tick && pos != '0) pos_n = pos - PW'(1);
      end else if (pos != PW'(RAMP_LEN) && (fast_q || slow_tick)) begin
         pos_n = pos + PW'(1);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pos    <= '0;
         fast_q <= 1'b1;
         div_q  <= '0;
      end else if (step_en) begin
         pos    <= pos_n;
         fast_q <= fast_n;
         div_q  <= div_q + DVW'(1);
      end
   end

   assign gain = tab[pos];
endmodule

// File: rtl/sar_scaler.sv
module sar_scaler #(
   parameter int DATA_W = 24,
   parameter int GAIN_W = 16
) (
   input  logic signed [DATA_W-1:0] x,
   input  logic        [GAIN_W-1:0] vol_g,
   input  logic        [GAIN_W-1:0] ramp_g,
   output logic signed [DATA_W-1:0] y
);
   localparam int GPW = 2 * GAIN_W;
   localparam int SH  = 2 * (GAIN_W - 1);
   localparam int PRW = DATA_W + GPW + 1;
   localparam logic signed [PRW-1:0] HALF = PRW'(1) <<< (SH - 1);
   localparam logic signed [PRW-1:0] HI   = PRW'((2 ** (DATA_W - 1)) - 1);
   localparam logic signed [PRW-1:0] LO   = -HI - PRW'(1);

   logic        [GPW-1:0] g;
   logic signed [PRW-1:0] prod, rnd, shf;

   always_comb begin
      g    = GPW'(vol_g) * GPW'(ramp_g);
      prod = x * $signed({1'b0, g});
      rnd  = prod + HALF;
      shf  = rnd >>> SH;
      if (shf > HI)      y = HI[DATA_W-1:0];
      else if (shf < LO) y = LO[DATA_W-1:0];
      else               y = shf[DATA_W-1:0];
   end
endmodule

// File: rtl/stereo_atten_ramp.sv
module stereo_atten_ramp #(
   parameter int DATA_W   = 24,
   parameter int CODE_W   = 6,
   parameter int GAIN_W   = 16,
   parameter int RAMP_LEN = 128,
   parameter int MUTE_DIV = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              smp_valid,
   input  logic [DATA_W-1:0] smp_left,
   input  logic [DATA_W-1:0] smp_right,
   input  logic [CODE_W-1:0] atten_code,
   input  logic              mute,
   input  logic              play_en,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_left,
   output logic [DATA_W-1:0] out_right
);
   localparam int PW    = $clog2(RAMP_LEN + 1);
   localparam int N_CH  = 2;

   if (DATA_W < 8 || DATA_W > 31) begin : g_bad_dw
      $error("DATA_W out of range");
   end
   if (GAIN_W < 8 || GAIN_W > 16) begin : g_bad_gw
      $error("GAIN_W out of range");
   end
   if (MUTE_DIV < 2 || (MUTE_DIV & (MUTE_DIV - 1)) != 0) begin : g_bad_div
      $error("MUTE_DIV must be a power of two, at least 2");
   end
   if (RAMP_LEN < 2) begin : g_bad_len
      $error("RAMP_LEN too small");
   end

   logic [GAIN_W-1:0] vol_g, ramp_g;
   logic [PW-1:0]     ramp_pos;

   sar_vol_rom #(.CODE_W(CODE_W), .GAIN_W(GAIN_W)) u_rom (
      .code (atten_code),
      .gain (vol_g)
   );

   sar_ramp #(.RAMP_LEN(RAMP_LEN), .MUTE_DIV(MUTE_DIV), .GAIN_W(GAIN_W)) u_ramp (
      .clk     (clk),
      .rst_n   (rst_n),
      .step_en (smp_valid),
      .play_en (play_en),
      .mute    (mute),
      .pos     (ramp_pos),
      .gain    (ramp_g)
   );

   logic signed [DATA_W-1:0] ch_in  [N_CH];
   logic signed [DATA_W-1:0] ch_out [N_CH];

   assign ch_in[0] = $signed(smp_left);
   assign ch_in[1] = $signed(smp_right);

   for (genvar c = 0; c < N_CH; c++) begin : g_ch
      sar_scaler #(.DATA_W(DATA_W), .GAIN_W(GAIN_W)) u_scl (
         .x      (ch_in[c]),
         .vol_g  (vol_g),
         .ramp_g (ramp_g),
         .y      (ch_out[c])
      );
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_left  <= '0;
         out_right <= '0;
      end else begin
         out_valid <= smp_valid;
         if (smp_valid) begin
            out_left  <= ch_out[0];
            out_right <= ch_out[1];
         end
      end
   end
endmodule

// File: rtl/sar_checker.sv
module sar_checker #(
   parameter int DATA_W   = 24,
   parameter int CODE_W   = 6,
   parameter int RAMP_LEN = 128,
   localparam int PW      = $clog2(RAMP_LEN + 1)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              smp_valid,
   input logic [CODE_W-1:0] atten_code,
   input logic              mute,
   input logic              play_en,
   input logic              out_valid,
   input logic [DATA_W-1:0] out_left,
   input logic [DATA_W-1:0] out_right,
   input logic [PW-1:0]     ramp_pos
);
   // R5
   valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      smp_valid |=> out_valid);
   // R5
   hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !smp_valid |=> (!out_valid && $stable(out_left) && $stable(out_right)));
   // R3
   silent_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_valid && atten_code >= CODE_W'(57)) |=> (out_left == '0 && out_right == '0));
   // R6
   pos_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ramp_pos <= PW'(RAMP_LEN));
   // R8
   no_jump_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ramp_pos == $past(ramp_pos)) || (ramp_pos == $past(ramp_pos) + PW'(1))
      || (ramp_pos + PW'(1) == $past(ramp_pos)));
   // R7
   mute_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (play_en && mute && smp_valid) |=> ramp_pos <= $past(ramp_pos));
   // R9
   power_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!play_en && smp_valid && ramp_pos != '0) |=> ramp_pos == $past(ramp_pos) - PW'(1));
   // R5
   pos_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !smp_valid |=> $stable(ramp_pos));
endmodule

bind stereo_atten_ramp sar_checker #(
   .DATA_W(DATA_W), .CODE_W(CODE_W), .RAMP_LEN(RAMP_LEN)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .smp_valid  (smp_valid),
   .atten_code (atten_code),
   .mute       (mute),
   .play_en    (play_en),
   .out_valid  (out_valid),
   .out_left   (out_left),
   .out_right  (out_right),
   .ramp_pos   (ramp_pos)
);

// File: tb/stereo_atten_ramp_bench.sv
module stereo_atten_ramp_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        smp_valid = 1'b0;
   logic [23:0] smp_left = '0, smp_right = '0;
   logic [5:0]  atten_code = '0;
   logic        mute = 1'b0, play_en = 1'b0;
   logic        out_valid;
   logic [23:0] out_left, out_right;

   always #10 clk = ~clk;

   stereo_atten_ramp u_stereo_atten_ramp (
      .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid),
      .smp_left(smp_left), .smp_right(smp_right), .atten_code(atten_code),
      .mute(mute), .play_en(play_en), .out_valid(out_valid),
      .out_left(out_left), .out_right(out_right));

   int    n_run = 0, n_fail = 0;
   string tag = "R11";
   bit    done = 1'b0;

   // ---- behavioural reference ----
   int     m_pos, m_cnt;
   bit     m_fast;
   logic [23:0] e_l = '0, e_r = '0;
   bit     e_v = 1'b0;

   function automatic longint gain_of(int code);
      int d;
      if (code <= 1) d = 0;
      else if (code <= 51) d = code - 1;
      else if (code == 52) d = 52;
      else if (code == 53) d = 54;
      else if (code == 54) d = 57;
      else if (code == 55) d = 60;
      else if (code == 56) d = 66;
      else return 0;
      return longint'($rtoi($pow(10.0, -real'(d) / 20.0) * 32768.0 + 0.5));
   endfunction

   function automatic longint ramp_of(int p);
      return longint'($rtoi(32768.0 * (1.0 - $cos(3.14159265358979323846 * real'(p) / 128.0)) / 2.0 + 0.5));
   endfunction

   function automatic logic [23:0] scale(logic [23:0] s, int code, int p);
      longint x, r;
      x = longint'($signed(s));
      r = (x * gain_of(code) * ramp_of(p) + (longint'(1) <<< 29)) >>> 30;
      if (r > 8388607) r = 8388607;
      if (r < -8388608) r = -8388608;
      return r[23:0];
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_pos = 0; m_cnt = 0; m_fast = 1'b1;
         e_l = '0; e_r = '0; e_v = 1'b0;
      end else begin
         e_v = smp_valid;
         if (smp_valid) begin
            e_l = scale(smp_left, int'(atten_code), m_pos);
            e_r = scale(smp_right, int'(atten_code), m_pos);
            if (!play_en) begin
               m_fast = 1'b1;
               if (m_pos > 0) m_pos--;
            end else if (mute) begin
               m_fast = 1'b0;
               if (m_cnt == 7 && m_pos > 0) m_pos--;
            end else if (m_pos < 128 && (m_fast || m_cnt == 7)) begin
               m_pos++;
            end
            m_cnt = (m_cnt + 1) % 8;
         end
      end
   end

   always @(negedge clk) begin
      if (rst_n && !done) begin
         n_run++;
         if (out_valid !== e_v || out_left !== e_l || out_right !== e_r) begin
            n_fail++;
            $display("FAIL %s: got v=%0b L=%h R=%h, expected v=%0b L=%h R=%h",
                     tag, out_valid, out_left, out_right, e_v, e_l, e_r);
         end
      end
   end

   // ---- stimulus ----
   int unsigned lfsr = 32'h1234_5678;
   function automatic logic [23:0] rnd24();
      lfsr = lfsr ^ (lfsr << 13);
      lfsr = lfsr ^ (lfsr >> 17);
      lfsr = lfsr ^ (lfsr << 5);
      return lfsr[23:0];
   endfunction

   task automatic send(logic [23:0] l, logic [23:0] r, int gap);
      @(negedge clk);
      smp_left = l; smp_right = r; smp_valid = 1'b1;
      @(negedge clk);
      smp_valid = 1'b0;
      for (int i = 0; i < gap; i++) @(negedge clk);
   endtask

   task automatic send_n(int n);
      for (int i = 0; i < n; i++) begin
         logic [23:0] a;
         a = rnd24();
         send(a, rnd24(), 0);
      end
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      n_fail++;
      n_run++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      // R11 reset state
      repeat (3) @(negedge clk);
      n_run++;
      if (out_valid !== 1'b0 || out_left !== 24'h0 || out_right !== 24'h0) begin
         n_fail++;
         $display("FAIL R11: got v=%0b L=%h R=%h, expected 0 0 0", out_valid, out_left, out_right);
      end
      rst_n = 1'b1;
      // R10 R6 power-up fast ramp from reset
      tag = "R10 R6 power-up";
      play_en = 1'b1;
      send_n(136);
      send(24'h0F4240, 24'h7FFFFF, 1);
      // R1 linear code range
      tag = "R1 code sweep";
      for (int c = 0; c <= 51; c++) begin
         atten_code = 6'(c);
         send(rnd24(), rnd24(), 0);
         send(24'h7FFFFF, 24'h800000, 0);
      end
      // R2 coarse codes
      tag = "R2 coarse codes";
      for (int c = 52; c <= 56; c++) begin
         atten_code = 6'(c);
         send(24'h7FFFFF, 24'h800000, 0);
         send(rnd24(), rnd24(), 0);
      end
      // R3 silence codes
      tag = "R3 silence";
      for (int c = 57; c <= 63; c++) begin
         atten_code = 6'(c);
         send(24'h7FFFFF, 24'h800000, 0);
      end
      // R4 channel match with unrelated data
      tag = "R4 channels";
      atten_code = 6'd20;
      send(24'h400000, 24'hC00000, 0);
      send(24'h000001, 24'h7FFFFF, 0);
      // R5 rounding and hold over gaps
      tag = "R5 rounding/hold";
      atten_code = 6'd7;
      send(24'h000003, 24'hFFFFFD, 4);
      send(24'h800000, 24'h7FFFFF, 7);
      send(24'h000000, 24'hFFFFFF, 2);
      // R7 slow mute, then R8 release mid-ramp
      tag = "R7 mute";
      atten_code = 6'd3;
      mute = 1'b1;
      send_n(600);
      tag = "R8 mid release";
      mute = 1'b0;
      send_n(300);
      tag = "R7 full mute";
      mute = 1'b1;
      send_n(1100);
      tag = "R8 full release";
      mute = 1'b0;
      send_n(1100);
      // R9 power-down fast roll-off
      tag = "R9 power-down";
      play_en = 1'b0;
      send_n(150);
      // power back while muted, then slow release
      tag = "R7 muted power-up";
      play_en = 1'b1; mute = 1'b1;
      send_n(20);
      tag = "R8 slow after mute";
      mute = 1'b0;
      send_n(200);
      tag = "R9 short power-down";
      play_en = 1'b0;
      send_n(60);
      tag = "R10 fast up";
      play_en = 1'b1;
      send_n(40);
      tag = "R10 mute during fast";
      mute = 1'b1;
      send_n(50);
      tag = "R8 release after";
      mute = 1'b0;
      send_n(100);
      repeat (3) @(negedge clk);
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule